// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt causes for a small 8-bit processor core and turns them into one of two request lines: a high-priority request and a low-priority request. It owns an 8-bit control register that holds the global gates, the enables and the sticky flags for three core sources: a timer overflow, an external edge and a port-change detector. It also takes a vector of peripheral request levels, and each of these carries its own priority bit.

A mode input selects between two schemes. In single-level mode, every request goes out on the high line. The top register bit is then a master gate, and the next bit gates only the peripheral vector. In two-level mode, each source is steered by its priority bit. The top register bit gates both lines, and the next bit gates only the low line. The flags record events whatever the enables hold, so software can also poll them.

The request lines come from a three-state arbiter: `ST_IDLE`, `ST_HIGH` and `ST_LOW`. From any state, the *raise-high* transition goes to `ST_HIGH` whenever a high request is pending. The *raise-low* transition goes to `ST_LOW` when only a low request is pending. The *drop* transition returns to `ST_IDLE` when nothing is pending. The state register drives the outputs, so a request appears one clock after the condition that causes it.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is active and right after it, register bits 7 to 1 read 0 and both request outputs are 0. The port-change flag (bit 0) has no defined reset value, and software clears it before use.
- R2: The register fields are: bit 7 global/high gate, bit 6 peripheral/low gate, bit 5 timer enable, bit 4 external enable, bit 3 port-change enable, bit 2 timer flag, bit 1 external flag, bit 0 port-change flag. A write with `wr_en` loads all eight bits, and `rdata` shows the register after the clock edge.
- R3: A `tmr_evt` or `ext_evt` pulse sets its flag at the next edge, whatever the enable and gate bits hold.
- R4: The timer and external flags stay set through idle cycles until a write puts 0 in them. Writing 1 sets them.
- R5: When a write clears a flag in the same cycle as an event for that flag, the flag stays set.
- R6: The port-change flag is set on every cycle in which some pin whose `port_chg_en` bit is 1 differs from the stored snapshot. Pins whose bit is 0 are ignored. A `port_rd` strobe loads the snapshot from the pins. While the mismatch lasts, a clearing write has no effect.
- R7: A core source requests only when both its flag and its enable are 1. A peripheral requests while its `periph_req` bit is 1.
- R8: When `prio_mode`=0, requests go only to `irq_hi`, and `irq_lo` stays 0. Bit 7 = 0 blocks every request. Bit 6 = 0 blocks the peripheral vector but not the core sources.
- R9: When `prio_mode`=1, a source whose priority bit is 1 requests high and a source whose bit is 0 requests low. `core_prio` bit 0 is the timer, bit 1 the external source and bit 2 the port change. Bit 7 = 0 blocks both lines, and bit 6 = 0 blocks only the low line.
- R10: When high and low requests are pending together, only `irq_hi` is driven, and the two outputs are never 1 together.
- R11: Each request output changes one clock after the register contents and inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register contents |
| prio_mode | input | 1 | 0 single-level, 1 two-level |
| tmr_evt | input | 1 | Timer overflow event pulse |
| ext_evt | input | 1 | External edge event pulse |
| port_pins | input | PORT_W | Monitored port pins |
| port_chg_en | input | PORT_W | Per-pin change-detect enables |
| port_rd | input | 1 | Snapshot load strobe (port read) |
| core_prio | input | 3 | Priority bits: timer, external, port change |
| periph_req | input | NPER | Peripheral request levels |
| periph_prio | input | NPER | Peripheral priority bits |
| irq_hi | output | 1 | High-priority request |
| irq_lo | output | 1 | Low-priority request |

## Verification
Register effects, meaning writes, flag sets from events and port mismatches, show on `rdata` after the edge that samples them. The request lines follow one edge after that, because the arbiter state register sits between the pending logic and the outputs. The bench changes its inputs shortly after each rising edge. A behavioural model updated on that same rising edge predicts both the register and the two request lines, and the bench compares all of them at every falling edge. This means each result is checked in the first cycle it is due and in every cycle after it.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } arb_state_e;

    localparam int REG_W    = 8;
    localparam int NCORE    = 3;

    localparam int B_GATE_H = 7;
    localparam int B_GATE_L = 6;
    localparam int B_TMR_EN = 5;
    localparam int B_EXT_EN = 4;
    localparam int B_PRT_EN = 3;
    localparam int B_TMR_FL = 2;
    localparam int B_EXT_FL = 1;
    localparam int B_PRT_FL = 0;

endpackage

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
    import irq_prio_pkg::*;
#(
    parameter int PORT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wdata,
    input  logic                 tmr_evt,
    input  logic                 ext_evt,
    input  logic [PORT_W-1:0]    port_pins,
    input  logic [PORT_W-1:0]    port_chg_en,
    input  logic                 port_rd,
    output logic [REG_W-1:0]     ctl_q
);

    logic [REG_W-1:1]  ctl_r;
    logic              prt_flag_r;
    logic [PORT_W-1:0] snap_r;
    logic              mismatch;

    assign mismatch = |((port_pins ^ snap_r) & port_chg_en);

    // Gates, enables and the two sticky flags; an event outranks a clearing write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_r  <= '0;
            snap_r <= '0;
        end else begin
            if (wr_en) begin
                ctl_r[B_GATE_H:B_PRT_EN] <= wdata[B_GATE_H:B_PRT_EN];
            end
            ctl_r[B_TMR_FL] <= tmr_evt | (wr_en ? wdata[B_TMR_FL] : ctl_r[B_TMR_FL]);
            ctl_r[B_EXT_FL] <= ext_evt | (wr_en ? wdata[B_EXT_FL] : ctl_r[B_EXT_FL]);
            if (port_rd) begin
                snap_r <= port_pins;
            end
        end
    end

    // Port-change flag has no defined reset value.
    always_ff @(posedge clk) begin
        prt_flag_r <= mismatch | (wr_en ? wdata[B_PRT_FL] : prt_flag_r);
    end

    assign ctl_q = {ctl_r, prt_flag_r};

    p_tmr_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_evt |=> ctl_q[B_TMR_FL]);

    p_ext_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_evt |=> ctl_q[B_EXT_FL]);

    p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[B_TMR_FL] && !wr_en) |=> ctl_q[B_TMR_FL]);

    p_evt_beats_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_evt && wr_en && !wdata[B_EXT_FL]) |=> ctl_q[B_EXT_FL]);

    p_mismatch_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> ctl_q[B_PRT_FL]);

endmodule

// File: rtl/irq_route.sv
module irq_route
    import irq_prio_pkg::*;
#(
    parameter int NPER = 8
) (
    input  logic               prio_mode,
    input  logic [REG_W-1:0]   ctl,
    input  logic [NCORE-1:0]   core_prio,
    input  logic [NPER-1:0]    periph_req,
    input  logic [NPER-1:0]    periph_prio,
    output logic               hi_pend,
    output logic               lo_pend
);

    logic [NCORE-1:0] core_act;
    logic gate_h, gate_l;
    logic leg_hi, tl_hi, tl_lo, src_hi, src_lo;

    // Core source i: flag at B_TMR_FL-i, enable at B_TMR_EN-i.
    for (genvar gi = 0; gi < NCORE; gi++) begin : g_core
        assign core_act[gi] = ctl[B_TMR_FL-gi] & ctl[B_TMR_EN-gi];
    end

    assign gate_h = ctl[B_GATE_H];
    assign gate_l = ctl[B_GATE_L];

    always_comb begin
        leg_hi = gate_h & ((|core_act) | (gate_l & (|periph_req)));
        src_hi = (|(core_act & core_prio))  | (|(periph_req & periph_prio));
        src_lo = (|(core_act & ~core_prio)) | (|(periph_req & ~periph_prio));
        tl_hi  = gate_h & src_hi;
        tl_lo  = gate_h & gate_l & src_lo;
        hi_pend = prio_mode ? tl_hi : leg_hi;
        lo_pend = prio_mode ? tl_lo : 1'b0;
    end

endmodule

// File: rtl/irq_arb_fsm.sv
module irq_arb_fsm
    import irq_prio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_pend,
    input  logic lo_pend,
    output logic irq_hi,
    output logic irq_lo
);

    arb_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_HIGH, ST_LOW: begin
                if (hi_pend)      state_d = ST_HIGH;  // raise-high
                else if (lo_pend) state_d = ST_LOW;   // raise-low
                else              state_d = ST_IDLE;  // drop
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_hi = 1'b0;
        irq_lo = 1'b0;
        unique case (state_q)
            ST_HIGH: irq_hi = 1'b1;
            ST_LOW:  irq_lo = 1'b1;
            default: ;
        endcase
    end

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_hi, irq_lo}));

    p_hi_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hi_pend |=> (irq_hi && !irq_lo));

    p_lo_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_pend && !hi_pend) |=> irq_lo);

    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_pend && !lo_pend) |=> (!irq_hi && !irq_lo));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int PORT_W = 4,
    parameter int NPER   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              prio_mode,
    input  logic              tmr_evt,
    input  logic              ext_evt,
    input  logic [PORT_W-1:0] port_pins,
    input  logic [PORT_W-1:0] port_chg_en,
    input  logic              port_rd,
    input  logic [2:0]        core_prio,
    input  logic [NPER-1:0]   periph_req,
    input  logic [NPER-1:0]   periph_prio,
    output logic              irq_hi,
    output logic              irq_lo
);

    logic [REG_W-1:0] ctl_q;
    logic hi_pend, lo_pend;

    irq_ctl_reg #(.PORT_W(PORT_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
        .tmr_evt(tmr_evt), .ext_evt(ext_evt), .port_pins(port_pins),
        .port_chg_en(port_chg_en), .port_rd(port_rd), .ctl_q(ctl_q)
    );

    irq_route #(.NPER(NPER)) u_route (
        .prio_mode(prio_mode), .ctl(ctl_q), .core_prio(core_prio),
        .periph_req(periph_req), .periph_prio(periph_prio),
        .hi_pend(hi_pend), .lo_pend(lo_pend)
    );

    irq_arb_fsm u_arb (
        .clk(clk), .rst_n(rst_n), .hi_pend(hi_pend), .lo_pend(lo_pend),
        .irq_hi(irq_hi), .irq_lo(irq_lo)
    );

    assign rdata = ctl_q;

    p_legacy_no_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> $past(prio_mode));

    // Bit 7 clear silences both lines in either mode (R8, R9).
    p_gate_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[B_GATE_H] |=> (!irq_hi && !irq_lo));

endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
    localparam int PW = 4;
    localparam int NP = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          prio_mode = 1'b0;
    logic          tmr_evt = 1'b0;
    logic          ext_evt = 1'b0;
    logic [PW-1:0] port_pins = '0;
    logic [PW-1:0] port_chg_en = '0;
    logic          port_rd = 1'b0;
    logic [2:0]    core_prio = '0;
    logic [NP-1:0] periph_req = '0;
    logic [NP-1:0] periph_prio = '0;
    logic          irq_hi, irq_lo;

    irq_prio_ctrl #(.PORT_W(PW), .NPER(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .prio_mode(prio_mode), .tmr_evt(tmr_evt), .ext_evt(ext_evt),
        .port_pins(port_pins), .port_chg_en(port_chg_en), .port_rd(port_rd),
        .core_prio(core_prio), .periph_req(periph_req), .periph_prio(periph_prio),
        .irq_hi(irq_hi), .irq_lo(irq_lo)
    );

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";
    bit    pf_known = 1'b0;
    bit    finished = 1'b0;

    // Reference model state
    logic [7:0]    m_ctl  = '0;
    logic [PW-1:0] m_snap = '0;
    logic          m_hi = 1'b0, m_lo = 1'b0;

    always @(posedge clk) begin : model
        logic t, e, p, hs, ls, mm;
        if (!rst_n) begin
            m_ctl[7:1] = '0;
            m_snap = '0;
            m_hi = 1'b0;
            m_lo = 1'b0;
        end else begin
            t = m_ctl[2] & m_ctl[5];
            e = m_ctl[1] & m_ctl[4];
            p = m_ctl[0] & m_ctl[3];
            if (!prio_mode) begin
                hs = m_ctl[7] & (t | e | p | (m_ctl[6] & (periph_req != 0)));
                ls = 1'b0;
            end else begin
                hs = m_ctl[7] & ((t & core_prio[0]) | (e & core_prio[1]) |
                                 (p & core_prio[2]) | ((periph_req & periph_prio) != 0));
                ls = m_ctl[7] & m_ctl[6] & ((t & !core_prio[0]) | (e & !core_prio[1]) |
                                 (p & !core_prio[2]) | ((periph_req & ~periph_prio) != 0));
            end
            m_hi = hs;
            m_lo = ls & !hs;
            mm = ((port_pins ^ m_snap) & port_chg_en) != 0;
            if (wr_en) begin
                m_ctl = wdata;
                pf_known = 1'b1;
            end
            if (tmr_evt) m_ctl[2] = 1'b1;
            if (ext_evt) m_ctl[1] = 1'b1;
            if (mm)      m_ctl[0] = 1'b1;
            if (port_rd) m_snap = port_pins;
        end
    end

    always @(negedge clk) begin : compare
        logic [7:0] mask;
        if (!finished) begin
            mask = pf_known ? 8'hFF : 8'hFE;
            checks++;
            if ((rdata & mask) !== (m_ctl & mask)) begin
                errors++;
                $display("FAIL %s: rdata=%02h expected %02h", phase, rdata & mask, m_ctl & mask);
            end
            checks++;
            if (irq_hi !== m_hi || irq_lo !== m_lo) begin
                errors++;
                $display("FAIL %s: hi/lo=%b%b expected %b%b", phase, irq_hi, irq_lo, m_hi, m_lo);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        phase = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        phase = "R2";
        wr(8'h00);
        wr(8'hF8);
        tick();
        wr(8'h28);
        wr(8'hC0);

        phase = "R3";
        tmr_evt = 1'b1; tick(); tmr_evt = 1'b0;
        ext_evt = 1'b1; tick(); ext_evt = 1'b0;
        repeat (2) tick();

        phase = "R4";
        repeat (4) tick();
        wr(8'hC2);
        tick();
        wr(8'hC0);
        wr(8'h04);
        wr(8'h00);

        phase = "R5";
        wr_en = 1'b1; wdata = 8'h00; tmr_evt = 1'b1; ext_evt = 1'b1;
        tick();
        wr_en = 1'b0; tmr_evt = 1'b0; ext_evt = 1'b0;
        tick();
        wr(8'h00);

        phase = "R6";
        port_chg_en = 4'b0011;
        port_pins   = 4'b0100;
        repeat (2) tick();
        port_pins   = 4'b0101;
        repeat (2) tick();
        wr(8'h00);
        port_rd = 1'b1; tick(); port_rd = 1'b0;
        tick();
        wr(8'h00);
        tick();

        phase = "R7";
        wr(8'h20);
        tmr_evt = 1'b1; tick(); tmr_evt = 1'b0;
        repeat (2) tick();

        phase = "R8";
        wr(8'hA4);
        repeat (2) tick();
        wr(8'h80);
        periph_req = 8'h10;
        repeat (2) tick();
        wr(8'hC0);
        repeat (2) tick();

        phase = "R9";
        prio_mode = 1'b1;
        periph_prio = 8'h00;
        repeat (2) tick();
        wr(8'h80);
        repeat (2) tick();
        periph_prio = 8'h10;
        repeat (2) tick();
        periph_prio = 8'h00;
        wr(8'h40);
        repeat (2) tick();

        phase = "R10";
        core_prio = 3'b001;
        wr(8'hE4);
        repeat (3) tick();
        wr(8'hC0);
        repeat (2) tick();

        phase = "R11";
        periph_req = '0;
        repeat (3) tick();
        wr(8'h00);
        prio_mode = 1'b0;
        repeat (2) tick();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R11: watchdog expired, state=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule